// File: doc/BRIEF.md
# GPIO Interrupt Front End with Shared Noise Filter

This block sits between up to 24 GPIO input lines and a parent interrupt controller. Each line is first synchronized. Every line then has three settings: an enable bit, a mode bit and a noise-filter enable bit. A single filter period count applies to all lines. Software programs these through a small register window at byte offsets 0x90 to 0x9C of the GPIO register space.

A line in normal mode passes its synchronized level straight to its interrupt output, gated by its enable bit. The parent controller then does its own level or single-edge sensing. A line in both-edge mode must have its filter enabled. The filter accepts a new level only after the synchronized input has held that level for the programmed number of cycles. Each accepted change, rising or falling, produces a one-cycle low pulse on the output, which the parent can capture as a falling edge. A separate level output gives the synchronized but unfiltered line state for the ordinary GPIO read path.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset the enable (0x90), mode (0x94) and filter-enable (0x98) registers read 0, the filter-period register (0x9C) reads 0xFF, and every interrupt output is 0.
- R2: Each of the three per-line registers stores one bit per line in bit i for line i. Write bits above the line count read back 0. The period register keeps only bits [7:0]. Reads of any other offset return 0.
- R3: A line in normal mode (mode bit 0) with its enable bit set drives its interrupt output to its input level, delayed by exactly two clock edges of synchronization.
- R4: A masked line (enable bit 0) holds its output at its idle level whatever its input does. The idle level is 0 in normal mode and 1 in both-edge mode.
- R5: An enabled line in both-edge mode (mode bit 1) with its filter enabled drives its output low for exactly one cycle on each accepted rising transition and on each accepted falling transition. Otherwise the output is 1.
- R6: The filter accepts a new level after the synchronized input has differed from the filtered level for P consecutive cycles, where P is the period register. A period of 0 behaves as 1. The pulse is therefore first visible 2+P clock edges after the input changes.
- R7: An input excursion that lasts fewer than P cycles produces no pulse.
- R8: A line in both-edge mode with its filter-enable bit 0 never pulses and holds its output at 1.
- R9: The level output for each line is its input delayed by two clock edges. Filter, mode and enable settings do not change it.
- R10: The period register is shared: one write changes the acceptance delay of every filtered line at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| gpio_i | input | NUM_LINES | Raw GPIO input lines |
| level_o | output | NUM_LINES | Synchronized, unfiltered line levels |
| irq_o | output | NUM_LINES | Per-line interrupt outputs to the parent controller |

## Verification
The one-cycle pulse property assumes that the period stays at 2 or more and that a line's mode and enable bits do not change while its pulse is pending. With a period of 1, two accepted changes can land on consecutive cycles. The directed stimulus reprograms configuration only while the filtered lines are quiet. It holds each input level far longer than the period, except in the deliberate short-glitch case. The synchronizer check assumes nothing about the inputs, because it compares against the inputs sampled two edges earlier.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned MAX_LINES = 24;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_FLT  = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_PER  = 8'h9C;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs import gpio_irq_pkg::*; #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned PER_W     = 8,
  parameter logic [PER_W-1:0] PER_RST = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] flt_o,
  output logic [PER_W-1:0]     per_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      mode_o <= '0;
      flt_o  <= '0;
      per_o  <= PER_RST;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_EN:   en_o   <= wdata_i[NUM_LINES-1:0];
        OFS_MODE: mode_o <= wdata_i[NUM_LINES-1:0];
        OFS_FLT:  flt_o  <= wdata_i[NUM_LINES-1:0];
        OFS_PER:  per_o  <= wdata_i[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_EN:   rdata_o[NUM_LINES-1:0] = en_o;
      OFS_MODE: rdata_o[NUM_LINES-1:0] = mode_o;
      OFS_FLT:  rdata_o[NUM_LINES-1:0] = flt_o;
      OFS_PER:  rdata_o[PER_W-1:0]     = per_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned STAGES    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] d_i,
  output logic [NUM_LINES-1:0] q_o
);
  logic [NUM_LINES-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             flt_en_i,
  input  logic [PER_W-1:0] per_i,
  output logic             chg_o
);
  logic [PER_W-1:0] cnt_q;
  logic             filt_q, filt_d_q;
  logic [PER_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      filt_q   <= 1'b0;
      filt_d_q <= 1'b0;
    end else begin
      filt_d_q <= filt_q;
      if (!flt_en_i) begin
        // bypassed filter tracks input so re-enabling adds no stale edge
        filt_q <= lvl_i;
        cnt_q  <= '0;
      end else if (lvl_i == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_nxt >= {1'b0, per_i}) begin
        filt_q <= lvl_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt[PER_W-1:0];
      end
    end
  end

  assign chg_o = filt_q ^ filt_d_q;
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front import gpio_irq_pkg::*; #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned PER_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NUM_LINES-1:0] gpio_i,
  output logic [NUM_LINES-1:0] level_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0] line_en, line_mode, line_flt, sync_lvl, line_chg;
  logic [PER_W-1:0]     flt_per;

  gpio_irq_regs #(.NUM_LINES(NUM_LINES), .PER_W(PER_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .en_o(line_en),
    .mode_o(line_mode), .flt_o(line_flt), .per_o(flt_per)
  );

  gpio_irq_sync #(.NUM_LINES(NUM_LINES), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gpio_i), .q_o(sync_lvl)
  );

  assign level_o = sync_lvl;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_irq_filter #(.PER_W(PER_W)) u_flt (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl[i]),
      .flt_en_i(line_flt[i]), .per_i(flt_per), .chg_o(line_chg[i])
    );
    // both-edge: idle high, low pulse per accepted change; normal: gated level
    assign irq_o[i] = line_mode[i] ? ~(line_en[i] & line_flt[i] & line_chg[i])
                                   : (line_en[i] & sync_lvl[i]);
  end
endmodule

// File: rtl/gpio_irq_front_chk.sv
module gpio_irq_front_chk #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned PER_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] gpio_i,
  input logic [NUM_LINES-1:0] level_o,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_LINES-1:0] en,
  input logic [NUM_LINES-1:0] mode,
  input logic [NUM_LINES-1:0] flt,
  input logic [PER_W-1:0]     per
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (level_o == $past(gpio_i, 2))); // R9

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ast
    AST_MASK_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en[i] && !mode[i]) |-> !irq_o[i]); // R4
    AST_MASK_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en[i] && mode[i]) |-> irq_o[i]); // R4
    AST_NOFILT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode[i] && !flt[i]) |-> irq_o[i]); // R8
    AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en[i] && mode[i] && flt[i] && per >= 2 && !irq_o[i])
        |=> (irq_o[i] || !(en[i] && mode[i]) || per < 2)); // R5
  end
endmodule

bind gpio_irq_front gpio_irq_front_chk #(.NUM_LINES(NUM_LINES), .PER_W(PER_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gpio_i(gpio_i), .level_o(level_o),
  .irq_o(irq_o), .en(line_en), .mode(line_mode), .flt(line_flt), .per(flt_per)
);

// File: tb/gpio_irq_front_bench.sv
module gpio_irq_front_bench;
  localparam int N = 24;
  logic        clk_i = 1'b0, rst_ni = 1'b0, reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic [N-1:0] gpio_i = '0, level_o, irq_o;
  int total = 0, bad = 0;
  logic [N-1:0] en_s = '0, mode_s = '0, flt_s = '0;

  always #10 clk_i = ~clk_i;

  gpio_irq_front u_gpio_irq_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .gpio_i(gpio_i),
    .level_o(level_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    reg_addr_i = a; #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic cfg();
    wr(8'h90, 32'(en_s)); wr(8'h94, 32'(mode_s)); wr(8'h98, 32'(flt_s));
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  // drive a line, measure first low cycle and pulse width
  task automatic measure(input int ln, input logic v, input int exp_first, input string req);
    int first = 0, width = 0;
    gpio_i[ln] = v;
    for (int c = 1; c <= exp_first + 6; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (c == 2) chk("R9 level", 32'(level_o[ln]), 32'(v));
      if (!irq_o[ln]) begin
        if (first == 0) first = c;
        width++;
      end
    end
    chk({req, " first"}, first, exp_first);
    chk("R5 width", width, 1);
  endtask

  task automatic t_reset();
    rd(8'h90, "R1 en", 0); rd(8'h94, "R1 mode", 0);
    rd(8'h98, "R1 flt", 0); rd(8'h9C, "R1 per", 32'hFF);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_regs();
    wr(8'h90, 32'hFFFF_FFFF); rd(8'h90, "R2 en width", 32'h00FF_FFFF);
    wr(8'h9C, 32'h1234);      rd(8'h9C, "R2 per width", 32'h34);
    rd(8'h80, "R2 unmapped", 0);
    wr(8'h90, 0); rd(8'h90, "R2 en clear", 0);
  endtask

  task automatic t_normal();
    en_s[3] = 1'b1; cfg();
    gpio_i[3] = 1'b1; gpio_i[5] = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk("R3 rise early", 32'(irq_o[3]), 0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R3 rise", 32'(irq_o[3]), 1);
    chk("R4 masked normal", 32'(irq_o[5]), 0);
    chk("R9 masked level", 32'(level_o[5]), 1);
    gpio_i[3] = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk("R3 fall early", 32'(irq_o[3]), 1);
    @(posedge clk_i); @(negedge clk_i);
    chk("R3 fall", 32'(irq_o[3]), 0);
    gpio_i[5] = 1'b0; idle(3);
  endtask

  task automatic t_both();
    wr(8'h9C, 4);
    en_s[7] = 1'b1; mode_s[7] = 1'b1; flt_s[7] = 1'b1; cfg();
    idle(2);
    chk("R5 idle", 32'(irq_o[7]), 1);
    measure(7, 1'b1, 6, "R6 rise");
    measure(7, 1'b0, 6, "R5 fall");
  endtask

  task automatic t_glitch();
    int lows = 0;
    gpio_i[7] = 1'b1; idle(3); gpio_i[7] = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (!irq_o[7]) lows++;
    end
    chk("R7 glitch", lows, 0);
  endtask

  task automatic t_nofilt();
    int lows = 0;
    en_s[9] = 1'b1; mode_s[9] = 1'b1;
    en_s[10] = 1'b0; mode_s[10] = 1'b1; flt_s[10] = 1'b1; cfg();
    for (int c = 0; c < 40; c++) begin
      if (c % 10 == 0) begin gpio_i[9] = ~gpio_i[9]; gpio_i[10] = ~gpio_i[10]; end
      @(posedge clk_i); @(negedge clk_i);
      if (!irq_o[9]) lows++;
      if (!irq_o[10]) lows += 100;
    end
    chk("R8 R4 silent", lows, 0);
  endtask

  task automatic t_shared();
    int f7 = 0, f11 = 0;
    en_s[11] = 1'b1; mode_s[11] = 1'b1; flt_s[11] = 1'b1; cfg();
    wr(8'h9C, 1); idle(3);
    gpio_i[7] = 1'b1; gpio_i[11] = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (!irq_o[7] && f7 == 0) f7 = c;
      if (!irq_o[11] && f11 == 0) f11 = c;
    end
    chk("R10 line7", f7, 3);
    chk("R10 line11", f11, 3);
    wr(8'h9C, 0); idle(3);
    measure(7, 1'b0, 3, "R6 zero");
    wr(8'h9C, 32'hFF); idle(3);
    measure(11, 1'b0, 257, "R6 full");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset(); t_regs(); t_normal(); t_both();
        t_glitch(); t_nofilt(); t_shared();
      end
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule